// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a serial slave on a two-wire SMBus that gives a host access to a bank of 8-bit configuration registers kept in an external register file. It samples SCL and SDA on the system clock and drives SDA only through an open-drain enable. Each transfer opens with a command byte. When bit 7 of that byte is set, bits 6:0 select one register for a single-byte read or write. When bit 7 is clear, the transfer is a counted block that always starts at register 0 and moves upward one register per byte.

A block write carries a byte count ahead of its data. A block read sends back the number of implemented registers before the register data, and the master ends the read with a NACK. A master may issue a Stop after any whole byte. The register file loads its own power-up defaults, so software does not have to use the interface at all. Writes from this block reach the file as single-cycle strobes on an address/data port. Reads come back through a registered read-data input, which suits a block RAM.

Top module: `smbus_cfg_slave`

## Requirements
- R1: The slave ACKs an address byte only when its upper seven bits equal 69h (D2h for a write, D3h for a read). For any other address it NACKs, and it keeps SDA released through the remaining bytes until the next Start or Stop.
- R2: A byte write (command bit 7 = 1, offset in bits 6:0) produces exactly one single-cycle write strobe carrying the first data byte at that offset. Every byte is ACKed. Further data bytes in the same transfer are ACKed and discarded.
- R3: A byte read (write phase with command bit 7 = 1, then a repeated Start and address D3h) returns the register at the offset, MSB first.
- R4: A block write (command 00h, then a byte count N) writes its data bytes to registers 0, 1, 2, … in order. Only the first N data bytes are written. Data bytes past N are ACKed and not written.
- R5: A block read (command 00h, then a repeated Start and D3h) first returns the register count 16 (10h), and then returns registers 0, 1, 2, … in order.
- R6: After the master NACKs a byte the slave has sent, the slave keeps SDA released until the next Start or Stop.
- R7: A Stop after any complete byte ends the transfer. Only the data bytes that were fully sent are written, and the next transfer behaves normally.
- R8: Offsets of 16 or above are out of range. Writes to them are ACKed but produce no write strobe, and reads from them return 00h.
- R9: The slave changes its SDA drive only while the synchronized SCL is low.
- R10: While reset is asserted, and on the first cycle after it, SDA is released and no write strobe is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low; low releases it |
| reg_addr | output | AW (4) | Register-file address for reads and writes |
| reg_wdata | output | 8 | Register-file write data |
| reg_we | output | 1 | Single-cycle register-file write strobe |
| reg_rdata | input | 8 | Register-file read data, one cycle after reg_addr |

## Verification
The bench targets block writes whose data run ends before the byte count and block writes whose data run goes past it. A design that ignored the count would write the extra bytes. A design that committed a byte before its eighth bit would leave a stray write after an early Stop. Block reads are stopped right after the count byte and also deep into the bank. Getting the pointer wrong shows up as a repeated register or a skipped one, and returning a register where the count belongs shifts every value by one. Out-of-range offsets, a foreign address and a master NACK are checked too. A slave that kept driving after any of these would corrupt the line, and the bench watches its drive directly.

// File: rtl/smbus_cfg_pkg.sv
package smbus_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } st_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_COUNT,
    PH_DATA
  } ph_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_ev_t;

endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    scl_s,
  output logic                    sda_s,
  output smbus_cfg_pkg::bus_ev_t  ev
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_p;
  logic              sda_p;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_i;
          sda_ff[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_ff[g-1];
          sda_ff[g] <= sda_ff[g-1];
        end
      end
    end
  end

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_comb begin
    ev.start = scl_s & scl_p & sda_p & ~sda_s;
    ev.stop  = scl_s & scl_p & ~sda_p & sda_s;
    ev.rise  = scl_s & ~scl_p;
    ev.fall  = ~scl_s & scl_p;
  end

endmodule

// File: rtl/smbus_tx_select.sv
module smbus_tx_select #(
  parameter int COUNT_VAL = 16
) (
  input  logic       send_count,
  input  logic       in_range,
  input  logic [7:0] rdata,
  output logic [7:0] byte_o
);

  localparam logic [7:0] CountByte = 8'(COUNT_VAL);

  always_comb begin
    if (send_count)    byte_o = CountByte;
    else if (in_range) byte_o = rdata;
    else               byte_o = 8'h00;
  end

endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave #(
  parameter logic [6:0] SLV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          reg_we,
  input  logic [7:0]    reg_rdata
);
  import smbus_cfg_pkg::*;

  localparam logic [7:0] LastPtr = 8'hFF;

  logic      scl_s;
  logic      sda_s;
  bus_ev_t   ev;
  st_e       st;
  ph_e       ph;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [7:0] ptr;
  logic [7:0] remain;
  logic       blk;
  logic       rnw;
  logic       data_seen;
  logic       adv;
  logic       cnt_next;
  logic       load_pend;
  logic       nack;
  logic       in_range;
  logic [7:0] tx_byte;

  smbus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .scl_s (scl_s),
    .sda_s (sda_s),
    .ev    (ev)
  );

  assign in_range = (ptr < 8'(NUM_REGS));
  assign reg_addr = ptr[AW-1:0];

  smbus_tx_select #(.COUNT_VAL(NUM_REGS)) u_txsel (
    .send_count (cnt_next),
    .in_range   (in_range),
    .rdata      (reg_rdata),
    .byte_o     (tx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ph        <= PH_ADDR;
      bitcnt    <= '0;
      shreg     <= '0;
      ptr       <= '0;
      remain    <= '0;
      blk       <= 1'b0;
      rnw       <= 1'b0;
      data_seen <= 1'b0;
      adv       <= 1'b0;
      cnt_next  <= 1'b0;
      load_pend <= 1'b0;
      nack      <= 1'b0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (ev.start) begin
        st        <= ST_RX;
        ph        <= PH_ADDR;
        bitcnt    <= '0;
        sda_oe    <= 1'b0;
        load_pend <= 1'b0;
        adv       <= 1'b0;
      end else if (ev.stop) begin
        st        <= ST_IDLE;
        sda_oe    <= 1'b0;
        load_pend <= 1'b0;
        adv       <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (ev.rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (ev.fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              case (ph)
                PH_ADDR: begin
                  if (shreg[7:1] == SLV_ADDR) begin
                    sda_oe <= 1'b1;
                    st     <= ST_RX_ACK;
                    rnw    <= shreg[0];
                  end else begin
                    st <= ST_IGNORE;
                  end
                end
                PH_CMD: begin
                  sda_oe    <= 1'b1;
                  st        <= ST_RX_ACK;
                  blk       <= ~shreg[7];
                  ptr       <= shreg[7] ? {1'b0, shreg[6:0]} : 8'd0;
                  data_seen <= 1'b0;
                  remain    <= '0;
                end
                PH_COUNT: begin
                  sda_oe <= 1'b1;
                  st     <= ST_RX_ACK;
                  remain <= shreg;
                end
                default: begin
                  sda_oe <= 1'b1;
                  st     <= ST_RX_ACK;
                  if (blk) begin
                    if (remain != 8'd0) begin
                      remain <= remain - 8'd1;
                      adv    <= 1'b1;
                      if (in_range) begin
                        reg_we    <= 1'b1;
                        reg_wdata <= shreg;
                      end
                    end
                  end else if (!data_seen) begin
                    data_seen <= 1'b1;
                    if (in_range) begin
                      reg_we    <= 1'b1;
                      reg_wdata <= shreg;
                    end
                  end
                end
              endcase
            end
          end

          ST_RX_ACK: begin
            if (ev.fall) begin
              sda_oe <= 1'b0;
              adv    <= 1'b0;
              if (adv && ptr != LastPtr) ptr <= ptr + 8'd1;
              case (ph)
                PH_ADDR: begin
                  if (rnw) begin
                    st        <= ST_TX;
                    load_pend <= 1'b1;
                    cnt_next  <= blk;
                  end else begin
                    st <= ST_RX;
                    ph <= PH_CMD;
                  end
                end
                PH_CMD: begin
                  st <= ST_RX;
                  ph <= blk ? PH_COUNT : PH_DATA;
                end
                default: begin
                  st <= ST_RX;
                  ph <= PH_DATA;
                end
              endcase
            end
          end

          ST_TX: begin
            if (load_pend) begin
              load_pend <= 1'b0;
              shreg     <= tx_byte;
              sda_oe    <= ~tx_byte[7];
              bitcnt    <= '0;
            end else if (ev.rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (ev.fall && bitcnt != 4'd0) begin
              if (bitcnt == 4'd8) begin
                sda_oe   <= 1'b0;
                st       <= ST_TX_ACK;
                bitcnt   <= '0;
                cnt_next <= 1'b0;
                if (!cnt_next && blk && ptr != LastPtr) ptr <= ptr + 8'd1;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          end

          ST_TX_ACK: begin
            if (ev.rise) begin
              nack   <= sda_s;
              bitcnt <= 4'd1;
            end else if (ev.fall && bitcnt == 4'd1) begin
              bitcnt <= '0;
              if (nack) begin
                st <= ST_IGNORE;
              end else begin
                st        <= ST_TX;
                load_pend <= 1'b1;
              end
            end
          end

          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/smbus_cfg_slave_chk.sv
module smbus_cfg_slave_chk (
  input logic                 clk,
  input logic                 rst,
  input logic                 scl_s,
  input logic                 sda_oe,
  input logic                 reg_we,
  input smbus_cfg_pkg::st_e   st
);
  import smbus_cfg_pkg::*;

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!sda_oe && !reg_we)); // R10

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (rst) !$stable(sda_oe) |-> !scl_s); // R9

  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) reg_we |=> !reg_we); // R2

  AST_WE_SCL_LOW: assert property (@(posedge clk) disable iff (rst) reg_we |-> !scl_s); // R4

  AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (rst) (st == ST_IGNORE) |-> !sda_oe); // R6

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst) (st == ST_IDLE) |-> !sda_oe); // R1

endmodule

bind smbus_cfg_slave smbus_cfg_slave_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .scl_s  (scl_s),
  .sda_oe (sda_oe),
  .reg_we (reg_we),
  .st     (st)
);

// File: tb/smbus_cfg_slave_bench.sv
`timescale 1ns/1ps
module smbus_cfg_slave_bench;

  localparam int NR = 16;
  localparam int AW = 4;
  localparam int Q  = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          scl_m = 1'b1;
  logic          sda_m = 1'b1;
  logic          sda_oe;
  logic [AW-1:0] reg_addr;
  logic [7:0]    reg_wdata;
  logic          reg_we;
  logic [7:0]    reg_rdata;
  logic          sda_line;

  logic [7:0] mem   [NR];
  logic [7:0] model [NR];
  int n_chk = 0;
  int n_fail = 0;
  int we_cnt = 0;
  int quiet_bad = 0;
  int r9_bad = 0;
  logic quiet_watch = 1'b0;
  logic prev_oe = 1'b0;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  smbus_cfg_slave u_smbus_cfg_slave (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata)
  );

  function automatic logic [7:0] dflt(input int i);
    return 8'(i * 29 + 5);
  endfunction

  function automatic logic [7:0] exp_rd(input int off);
    return (off < NR) ? model[off] : 8'h00;
  endfunction

  // register file with power-up defaults and registered read
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NR; i++) mem[i] <= dflt(i);
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
    reg_rdata <= mem[reg_addr];
  end

  always @(posedge clk) if (!rst && reg_we) we_cnt <= we_cnt + 1;

  always @(negedge clk) begin
    if (!rst && quiet_watch && sda_oe) quiet_bad <= quiet_bad + 1;
    if (!rst && (sda_oe != prev_oe) && scl_m) r9_bad <= r9_bad + 1;
    prev_oe <= sda_oe;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq(1);
    sda_m = 1'b0; wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b0; wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(1);
      scl_m = 1'b1; wq(2);
      scl_m = 1'b0; wq(1);
    end
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    ack = (sda_line == 1'b0);
    wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    b = 8'h00;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(1);
      scl_m = 1'b1; wq(1);
      b = {b[6:0], sda_line};
      wq(1);
      scl_m = 1'b0;
    end
    wq(1);
    sda_m = nack; wq(1);
    scl_m = 1'b1; wq(2);
    scl_m = 1'b0; wq(1);
    sda_m = 1'b1;
  endtask

  task automatic byte_write(input int off, input logic [7:0] d);
    logic ack;
    int w0;
    w0 = we_cnt;
    bus_start();
    send_byte(8'hD2, ack); check("R1 addr ack", ack, 1);
    send_byte({1'b1, 7'(off)}, ack); check("R2 cmd ack", ack, 1);
    send_byte(d, ack); check("R2 data ack", ack, 1);
    bus_stop();
    if (off < NR) begin
      model[off] = d;
      check("R2 one strobe", we_cnt - w0, 1);
    end else begin
      check("R8 no strobe out of range", we_cnt - w0, 0);
    end
  endtask

  task automatic byte_read(input int off);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD2, ack); check("R1 addr ack", ack, 1);
    send_byte({1'b1, 7'(off)}, ack); check("R3 cmd ack", ack, 1);
    bus_rstart();
    send_byte(8'hD3, ack); check("R1 read addr ack", ack, 1);
    recv_byte(1'b1, b);
    if (off < NR) check("R3 byte read data", b, exp_rd(off));
    else          check("R8 out-of-range read 00h", b, 0);
    quiet_watch = 1'b1;
    bus_stop();
    quiet_watch = 1'b0;
  endtask

  task automatic block_write(input int cnt, input int nsend);
    logic ack;
    logic [7:0] d;
    int w0;
    int nw;
    w0 = we_cnt;
    nw = 0;
    bus_start();
    send_byte(8'hD2, ack); check("R1 addr ack", ack, 1);
    send_byte(8'h00, ack); check("R4 cmd ack", ack, 1);
    send_byte(8'(cnt), ack); check("R4 count ack", ack, 1);
    for (int i = 0; i < nsend; i++) begin
      d = 8'($urandom);
      send_byte(d, ack); check("R4 data ack", ack, 1);
      if (i < cnt && i < NR) begin
        model[i] = d;
        nw++;
      end
    end
    bus_stop();
    if (nsend < cnt) check("R7 early stop strobes", we_cnt - w0, nw);
    else             check("R4 block strobes", we_cnt - w0, nw);
  endtask

  task automatic block_read(input int nread);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD2, ack); check("R1 addr ack", ack, 1);
    send_byte(8'h00, ack); check("R5 cmd ack", ack, 1);
    bus_rstart();
    send_byte(8'hD3, ack); check("R1 read addr ack", ack, 1);
    recv_byte(nread == 0, b);
    check("R5 count byte", b, NR);
    for (int i = 0; i < nread; i++) begin
      recv_byte(i == nread - 1, b);
      check("R5 block data", b, exp_rd(i));
    end
    quiet_watch = 1'b1;
    wq(4);
    bus_stop();
    quiet_watch = 1'b0;
    check("R6 released after NACK", quiet_bad, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int seed_init;
    logic ack;
    int w0;
    seed_init = $urandom(32'd20240611);
    for (int i = 0; i < NR; i++) model[i] = dflt(i);
    repeat (5) @(negedge clk);
    check("R10 sda released in reset", sda_oe, 0);
    check("R10 no strobe in reset", reg_we, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 sda released after reset", sda_oe, 0);
    wq(2);

    // defaults readable before any write
    block_read(NR);
    byte_read(5);

    // foreign address: NACK and silence
    w0 = we_cnt;
    bus_start();
    send_byte(8'hA4, ack); check("R1 foreign addr nack", ack, 0);
    quiet_watch = 1'b1;
    send_byte(8'h83, ack); check("R1 ignored cmd not acked", ack, 0);
    send_byte(8'h5A, ack); check("R1 ignored data not acked", ack, 0);
    bus_stop();
    quiet_watch = 1'b0;
    check("R1 foreign addr silent", quiet_bad, 0);
    check("R1 foreign addr no write", we_cnt - w0, 0);
    byte_read(3);

    // byte write with extra bytes discarded
    w0 = we_cnt;
    bus_start();
    send_byte(8'hD2, ack); check("R1 addr ack", ack, 1);
    send_byte(8'h87, ack); check("R2 cmd ack", ack, 1);
    send_byte(8'hC3, ack); check("R2 data ack", ack, 1);
    send_byte(8'h11, ack); check("R2 extra data ack", ack, 1);
    bus_stop();
    model[7] = 8'hC3;
    check("R2 only first byte written", we_cnt - w0, 1);
    byte_read(7);

    // out-of-range offsets
    byte_write(16, 8'hEE);
    byte_write(127, 8'h77);
    byte_read(16);
    byte_read(100);

    // block write corners
    block_write(4, 4);
    block_write(6, 8);
    block_write(10, 3);
    block_read(5);
    block_read(0);
    block_write(20, 18);
    block_read(NR + 2);
    byte_write(15, 8'h3C);
    byte_read(15);

    // constrained random mix
    for (int k = 0; k < 18; k++) begin
      int op;
      int off;
      int cnt;
      op  = $urandom_range(0, 3);
      off = $urandom_range(0, 31);
      cnt = $urandom_range(0, 12);
      case (op)
        0: byte_write(off, 8'($urandom));
        1: byte_read(off);
        2: block_write(cnt, $urandom_range(0, cnt + 2));
        default: block_read($urandom_range(0, NR));
      endcase
    end

    check("R9 sda changes only with scl low", r9_bad, 0);
    summary();
    $finish;
  end

endmodule